// File: doc/BRIEF.md
# Half-Precision Fused Multiply-Subtract Unit

This block computes `addend - (mcand * mplier)` on IEEE binary16 operands (1 sign, 5 exponent and 10 fraction bits). The product is never rounded. It is kept exactly and summed with the addend in a wide fixed-point accumulator. The exact sum is rounded once, to nearest with ties to even. The negation is applied to the multiplicand before the product is formed, so the signs of zero results and the sign of a NaN that is propagated from the multiplicand come from that negated input. The result is meant to overwrite the lane that supplied the addend.

A valid/ready handshake accepts one operand triple at a time. A three-state controller sequences each operation. In **IDLE** the unit is ready, and transition **ACCEPT** captures the operands when `in_valid` is high. In **EXEC** the exact sum is formed and rounded, and transition **COMPUTE** registers the result. In **HOLD** the result is presented. Transition **STALL** keeps the unit in HOLD while `out_ready` is low. Transition **RETIRE** returns it to IDLE when `out_ready` is high. Subnormal inputs and outputs are fully supported. Four exception flags are reported with every result.

Top module: `hfms_unit`

## Requirements
- R1: For finite, non-NaN operands, `out_result` is the binary16 value nearest to the exact value `addend - mcand*mplier`, with ties going to an even fraction. No intermediate rounding is applied. The `inexact` flag is raised exactly when the rounded result differs from the exact value.
- R2: `out_flags` is packed as: bit 3 = invalid, bit 2 = overflow, bit 1 = underflow, bit 0 = inexact.
- R3: When the rounded magnitude reaches the infinity exponent (field 31), the result is an infinity of the sum's sign and both overflow and inexact are set.
- R4: Subnormal operands are used at full precision, and subnormal results are produced. Underflow is raised when the exact nonzero sum is below 2^-14 in magnitude and the result is inexact. Underflow never appears without inexact.
- R5: Infinity times zero in either order, and an infinite addend combined with an infinite product of opposite effective sign, return the default NaN 0x7E00 with only the invalid flag set. This holds only when no input is a NaN.
- R6: If any input is a NaN, the result is the first NaN in the order addend, mcand, mplier, with fraction bit 9 forced to 1. A NaN taken from mcand has its sign bit inverted.
- R7: A signalling NaN input (exponent 31, fraction nonzero, fraction bit 9 clear) sets invalid. A NaN input that is only quiet sets no flag.
- R8: An exact zero sum returns -0 only when the addend and the negated product are both negative. Every other exact zero is +0.
- R9: With no NaN and no invalid case, an infinite addend or product gives an infinity of that term's sign with no flags.
- R10: `in_ready` is high only in IDLE, and `in_ready` and `out_valid` are never high together.
- R11: `out_valid` rises at the second rising edge after the edge that accepts the operands (`in_valid && in_ready`).
- R12: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_flags` hold their values. `out_ready` high in HOLD retires the result.
- R13: After reset the unit is in IDLE with `in_ready` high and `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand triple is presented |
| in_ready | output | 1 | Unit can accept operands (IDLE) |
| in_addend | input | 16 | Addend / destination lane value |
| in_mcand | input | 16 | Multiplicand (negated internally) |
| in_mplier | input | 16 | Multiplier |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 16 | Rounded binary16 result |
| out_flags | output | 4 | {invalid, overflow, underflow, inexact} |

## Verification
The bench builds the block with the package defaults of a 5-bit exponent and a 10-bit fraction. With that narrow exponent range, the directed cases reach every special corner: ties at the subnormal boundary, rounding from the largest subnormal up into the smallest normal, overflow from a product near the largest finite value, and exact cancellation that only a fused unit resolves. Pseudo-random triples are biased toward near-cancellation and tiny exponents. They are compared against a rounding model in the bench that shifts out one bit at a time, so the far-apart and subnormal alignments of the wide accumulator are exercised as well.

// File: rtl/hfms_pkg.sv
package hfms_pkg;
    // Format
    localparam int EXP_W    = 5;
    localparam int FRAC_W   = 10;
    localparam int FP_W     = 1 + EXP_W + FRAC_W;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX  = (1 << EXP_W) - 1;
    localparam int N_OPS    = 3;
    localparam int FLAG_W   = 4;

    // Fixed-point accumulator: LSB weight is the smallest product step
    localparam int LSB_EXP  = 2 * (1 - BIAS - FRAC_W);
    localparam int ADD_OFF  = -(BIAS + FRAC_W) - LSB_EXP;
    localparam int PROD_OFF = -2 * (BIAS + FRAC_W) - LSB_EXP;
    localparam int SUB_POS  = 1 - BIAS - FRAC_W - LSB_EXP;
    localparam int ACC_W    = 2 * SIG_W + 2 * (EXP_MAX - 1) + PROD_OFF + 2;
    localparam int IDX_W    = $clog2(ACC_W);
    localparam int ENC_W    = IDX_W + FRAC_W + 1;

    localparam logic [FP_W-1:0] SIGN_BIT = FP_W'(1) << (FP_W - 1);
    localparam logic [FP_W-1:0] QUIET_BIT = FP_W'(1) << (FRAC_W - 1);
    localparam logic [FP_W-1:0] INF_MAG = FP_W'(EXP_MAX) << FRAC_W;
    localparam logic [FP_W-1:0] DEF_NAN = INF_MAG | QUIET_BIT;

    // Operand indices
    localparam int OP_ADD = 0;
    localparam int OP_MCD = 1;
    localparam int OP_MPL = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_HOLD = 2'd2
    } fsm_state_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;   // effective exponent, subnormal -> 1
        logic [SIG_W-1:0]  sig;   // significand with hidden bit
        logic              zero;
        logic              inf;
        logic              nan;
        logic              snan;
    } hf_op_t;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } hf_flags_t;
endpackage

// File: rtl/hfms_classify.sv
module hfms_classify
    import hfms_pkg::*;
(
    input  logic [FP_W-1:0] raw,
    output hf_op_t          op
);
    logic [EXP_W-1:0]  fld_exp;
    logic [FRAC_W-1:0] fld_frac;
    logic              exp_zero;
    logic              exp_ones;
    logic              frac_zero;

    always_comb begin
        fld_exp   = raw[FP_W-2:FRAC_W];
        fld_frac  = raw[FRAC_W-1:0];
        exp_zero  = (fld_exp == '0);
        exp_ones  = (fld_exp == EXP_W'(EXP_MAX));
        frac_zero = (fld_frac == '0);

        op.sign = raw[FP_W-1];
        op.exp  = exp_zero ? EXP_W'(1) : fld_exp;
        op.sig  = {~exp_zero, fld_frac};
        op.zero = exp_zero & frac_zero;
        op.inf  = exp_ones & frac_zero;
        op.nan  = exp_ones & ~frac_zero;
        op.snan = exp_ones & ~frac_zero & ~fld_frac[FRAC_W-1];
    end
endmodule

// File: rtl/hfms_core.sv
module hfms_core
    import hfms_pkg::*;
(
    input  hf_op_t          op_c,
    input  hf_op_t          op_a,
    input  hf_op_t          op_b,
    input  logic [FP_W-1:0] raw_c,
    input  logic [FP_W-1:0] raw_a,
    input  logic [FP_W-1:0] raw_b,
    output logic [FP_W-1:0] res,
    output hf_flags_t       flags
);
    // sign of the term -(a*b)
    logic                 sgn_p;
    logic                 any_nan;
    logic                 any_snan;
    logic                 zero_inf;
    logic                 prod_inf;
    logic                 inf_clash;

    logic [2*SIG_W-1:0]   sig_prod;
    logic [IDX_W-1:0]     add_sh;
    logic [IDX_W-1:0]     prod_sh;
    logic [ACC_W-1:0]     add_mag;
    logic [ACC_W-1:0]     prod_mag;
    logic [ACC_W-1:0]     add_term;
    logic [ACC_W-1:0]     prod_term;
    logic [ACC_W-1:0]     sum;
    logic [ACC_W-1:0]     mag;
    logic [ACC_W-1:0]     low_mask;
    logic                 neg;

    logic [IDX_W-1:0]     lead;
    logic [IDX_W-1:0]     sh;
    logic [SIG_W-1:0]     kept;
    logic                 rnd_bit;
    logic                 sticky;
    logic                 inc;
    logic [SIG_W:0]       rounded;
    logic [ENC_W-1:0]     enc;
    logic                 tiny;

    logic [FP_W-1:0]      fin_res;
    hf_flags_t            fin_flags;

    // Exact alignment and sum of both terms
    always_comb begin
        sgn_p     = ~op_a.sign ^ op_b.sign;
        sig_prod  = op_a.sig * op_b.sig;
        add_sh    = IDX_W'(op_c.exp) + IDX_W'(ADD_OFF);
        prod_sh   = IDX_W'(op_a.exp) + IDX_W'(op_b.exp) + IDX_W'(PROD_OFF);
        add_mag   = ACC_W'(op_c.sig) << add_sh;
        prod_mag  = ACC_W'(sig_prod) << prod_sh;
        add_term  = op_c.sign ? -add_mag  : add_mag;
        prod_term = sgn_p     ? -prod_mag : prod_mag;
        sum       = add_term + prod_term;
        neg       = sum[ACC_W-1];
        mag       = neg ? -sum : sum;
    end

    // Normalise, round to nearest even, encode
    always_comb begin
        lead = '0;
        for (int i = 0; i < ACC_W; i++) begin
            if (mag[i]) lead = IDX_W'(i);
        end
        if (lead > IDX_W'(SUB_POS + FRAC_W)) sh = lead - IDX_W'(FRAC_W);
        else                                 sh = IDX_W'(SUB_POS);

        kept     = SIG_W'(mag >> sh);
        rnd_bit  = mag[sh - IDX_W'(1)];
        low_mask = (ACC_W'(1) << (sh - IDX_W'(1))) - ACC_W'(1);
        sticky   = |(mag & low_mask);
        inc      = rnd_bit & (sticky | kept[0]);
        rounded  = {1'b0, kept} + {{SIG_W{1'b0}}, inc};
        enc      = (ENC_W'(sh - IDX_W'(SUB_POS)) << FRAC_W) + ENC_W'(rounded);
        tiny     = lead < IDX_W'(SUB_POS + FRAC_W);

        fin_flags = '0;
        if (mag == '0) begin
            fin_res = (op_c.sign & sgn_p) ? SIGN_BIT : '0;
        end else if (enc >= (ENC_W'(EXP_MAX) << FRAC_W)) begin
            fin_res            = neg ? (SIGN_BIT | INF_MAG) : INF_MAG;
            fin_flags.overflow = 1'b1;
            fin_flags.inexact  = 1'b1;
        end else begin
            fin_res             = {neg, enc[FP_W-2:0]};
            fin_flags.inexact   = rnd_bit | sticky;
            fin_flags.underflow = (rnd_bit | sticky) & tiny;
        end
    end

    // Special operand handling, highest priority first
    always_comb begin
        any_nan   = op_c.nan | op_a.nan | op_b.nan;
        any_snan  = op_c.snan | op_a.snan | op_b.snan;
        zero_inf  = (op_a.inf & op_b.zero) | (op_a.zero & op_b.inf);
        prod_inf  = op_a.inf | op_b.inf;
        inf_clash = prod_inf & op_c.inf & (sgn_p != op_c.sign);

        flags = '0;
        if (any_nan) begin
            if (op_c.nan)      res = raw_c | QUIET_BIT;
            else if (op_a.nan) res = (raw_a ^ SIGN_BIT) | QUIET_BIT;
            else               res = raw_b | QUIET_BIT;
            flags.invalid = any_snan;
        end else if (zero_inf | inf_clash) begin
            res           = DEF_NAN;
            flags.invalid = 1'b1;
        end else if (op_c.inf) begin
            res = op_c.sign ? (SIGN_BIT | INF_MAG) : INF_MAG;
        end else if (prod_inf) begin
            res = sgn_p ? (SIGN_BIT | INF_MAG) : INF_MAG;
        end else begin
            res   = fin_res;
            flags = fin_flags;
        end
    end
endmodule

// File: rtl/hfms_ctrl.sv
module hfms_ctrl
    import hfms_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load_op,
    output logic load_res
);
    fsm_state_t state_q;
    fsm_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_EXEC;   // ACCEPT
            ST_EXEC:                state_d = ST_HOLD;   // COMPUTE
            ST_HOLD: if (out_ready) state_d = ST_IDLE;   // RETIRE, else STALL
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load_op   = 1'b0;
        load_res  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                load_op  = in_valid;
            end
            ST_EXEC: load_res  = 1'b1;
            ST_HOLD: out_valid = 1'b1;
            default: ;
        endcase
    end

    // R11
    accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !out_valid) ##1 out_valid);

    // R10
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));
endmodule

// File: rtl/hfms_unit.sv
module hfms_unit
    import hfms_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FP_W-1:0]   in_addend,
    input  logic [FP_W-1:0]   in_mcand,
    input  logic [FP_W-1:0]   in_mplier,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [FP_W-1:0]   out_result,
    output logic [FLAG_W-1:0] out_flags
);
    logic            load_op;
    logic            load_res;
    logic [FP_W-1:0] in_vec  [N_OPS];
    logic [FP_W-1:0] opnd_q  [N_OPS];
    hf_op_t          opc     [N_OPS];
    logic [FP_W-1:0] core_res;
    hf_flags_t       core_flags;
    logic [FP_W-1:0] res_q;
    hf_flags_t       flags_q;

    assign in_vec[OP_ADD] = in_addend;
    assign in_vec[OP_MCD] = in_mcand;
    assign in_vec[OP_MPL] = in_mplier;

    hfms_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load_op   (load_op),
        .load_res  (load_res)
    );

    for (genvar g = 0; g < N_OPS; g++) begin : g_opnd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       opnd_q[g] <= '0;
            else if (load_op) opnd_q[g] <= in_vec[g];
        end

        hfms_classify u_cls (
            .raw (opnd_q[g]),
            .op  (opc[g])
        );
    end

    hfms_core u_core (
        .op_c  (opc[OP_ADD]),
        .op_a  (opc[OP_MCD]),
        .op_b  (opc[OP_MPL]),
        .raw_c (opnd_q[OP_ADD]),
        .raw_a (opnd_q[OP_MCD]),
        .raw_b (opnd_q[OP_MPL]),
        .res   (core_res),
        .flags (core_flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (load_res) begin
            res_q   <= core_res;
            flags_q <= core_flags;
        end
    end

    assign out_result = res_q;
    assign out_flags  = flags_q;

    // R12
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_result) && $stable(out_flags)));

    // R3
    ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[2]) |->
            (out_result[FP_W-2:0] == INF_MAG[FP_W-2:0] && out_flags[0]));

    // R6
    nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result[FP_W-2:FRAC_W] == EXP_W'(EXP_MAX)
                   && out_result[FRAC_W-1:0] != '0) |-> out_result[FRAC_W-1]);

    // R4
    uf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[1]) |-> out_flags[0]);
endmodule

// File: tb/hfms_unit_tb.sv
module hfms_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_addend = '0;
    logic [15:0] in_mcand = '0;
    logic [15:0] in_mplier = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_result;
    logic [3:0]  out_flags;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    hfms_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_addend  (in_addend),
        .in_mcand   (in_mcand),
        .in_mplier  (in_mplier),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_result (out_result),
        .out_flags  (out_flags)
    );

    task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Send one triple, check handshake timing, return the result.
    task automatic apply(input logic [15:0] c, a, b,
                         output logic [15:0] r, output logic [3:0] f);
        @(negedge clk);
        in_addend = c; in_mcand = a; in_mplier = b; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check_val("R10 in_ready low after accept", 32'(in_ready), 32'd0);
        @(negedge clk);
        check_val("R11 out_valid one cycle after exec", 32'(out_valid), 32'd1);
        r = out_result;
        f = out_flags;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic expect_op(string tag, logic [15:0] c, a, b,
                             logic [15:0] er, logic [3:0] ef);
        logic [15:0] r;
        logic [3:0]  f;
        apply(c, a, b, r, f);
        check_val(tag, {12'd0, f, r}, {12'd0, ef, er});
    endtask

    // Independent reference: exact integer sum, one-bit-at-a-time rounding
    function automatic logic [19:0] ref_model(logic [15:0] c, a, b);
        logic [4:0] ec, ea, eb;
        logic [9:0] fc, fa, fb;
        logic nc, na, nb, sc, sa, sb, sp, s;
        logic [95:0] av, pv, mag, m;
        logic [10:0] mc, ma, mb;
        int xc, xa, xb, e_res, biased;
        logic rnd, stk, tiny;
        logic [3:0] fl;
        sc = c[15]; sa = a[15]; sb = b[15];
        ec = c[14:10]; ea = a[14:10]; eb = b[14:10];
        fc = c[9:0]; fa = a[9:0]; fb = b[9:0];
        nc = (ec == 5'h1F) && (fc != 0);
        na = (ea == 5'h1F) && (fa != 0);
        nb = (eb == 5'h1F) && (fb != 0);
        sp = ~sa ^ sb;
        fl = 4'b0;
        if (nc || na || nb) begin
            fl[3] = (nc && !fc[9]) || (na && !fa[9]) || (nb && !fb[9]);
            if (nc)      return {fl, c | 16'h0200};
            else if (na) return {fl, (a ^ 16'h8000) | 16'h0200};
            else         return {fl, b | 16'h0200};
        end
        if (((ea == 5'h1F) && (b[14:0] == 0)) || ((eb == 5'h1F) && (a[14:0] == 0)))
            return {4'b1000, 16'h7E00};
        if ((ea == 5'h1F || eb == 5'h1F) && ec == 5'h1F && sp != sc)
            return {4'b1000, 16'h7E00};
        if (ec == 5'h1F) return {4'b0000, sc, 15'h7C00};
        if (ea == 5'h1F || eb == 5'h1F) return {4'b0000, sp, 15'h7C00};
        mc = (ec != 0) ? {1'b1, fc} : {1'b0, fc};
        ma = (ea != 0) ? {1'b1, fa} : {1'b0, fa};
        mb = (eb != 0) ? {1'b1, fb} : {1'b0, fb};
        xc = (ec != 0) ? int'(ec) : 1;
        xa = (ea != 0) ? int'(ea) : 1;
        xb = (eb != 0) ? int'(eb) : 1;
        av = 96'(mc) << (xc + 23);
        pv = (96'(ma) * 96'(mb)) << (xa + xb - 2);
        if (sc == sp)      begin mag = av + pv; s = sc; end
        else if (av >= pv) begin mag = av - pv; s = sc; end
        else               begin mag = pv - av; s = sp; end
        if (mag == 0) return {4'b0000, (sc & sp), 15'h0};
        tiny = mag < (96'd1 << 34);
        m = mag; e_res = -48; rnd = 0; stk = 0;
        while (m >= 96'd2048 || e_res < -24) begin
            stk = stk | rnd;
            rnd = m[0];
            m = m >> 1;
            e_res++;
        end
        if (rnd && (stk || m[0])) m = m + 1;
        if (m == 96'd2048) begin m = 96'd1024; e_res++; end
        fl[0] = rnd | stk;
        if (m >= 96'd1024) begin
            biased = e_res + 25;
            if (biased >= 31) return {4'b0101, s, 15'h7C00};
            fl[1] = fl[0] && tiny;
            return {fl, s, biased[4:0], m[9:0]};
        end
        fl[1] = fl[0] && tiny;
        return {fl, s, 5'd0, m[9:0]};
    endfunction

    function automatic logic [31:0] xs_next(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic test_reset();
        check_val("R13 in_ready after reset", 32'(in_ready), 32'd1);
        check_val("R13 out_valid after reset", 32'(out_valid), 32'd0);
    endtask

    task automatic test_basic();
        expect_op("R1 3-1*2", 16'h4200, 16'h3C00, 16'h4000, 16'h3C00, 4'b0000);
        expect_op("R1 0-2*3", 16'h0000, 16'h4000, 16'h4200, 16'hC600, 4'b0000);
        // exact product kept: (1+2^-9) - (1+2^-10)^2 = -2^-20
        expect_op("R1 fused no intermediate rounding", 16'h3C02, 16'h3C01, 16'h3C01,
                  16'h8010, 4'b0000);
    endtask

    task automatic test_round_even();
        expect_op("R1 tie to even down", 16'h3C00, 16'h1000, 16'hBC00, 16'h3C00, 4'b0001);
        expect_op("R1 tie to even up", 16'h3C01, 16'h1000, 16'hBC00, 16'h3C02, 4'b0001);
    endtask

    task automatic test_overflow();
        expect_op("R3 R2 overflow to -inf", 16'h0000, 16'h7BFF, 16'h4000, 16'hFC00, 4'b0101);
    endtask

    task automatic test_subnormal();
        expect_op("R4 half of min subnormal ties to zero", 16'h0000, 16'h0001, 16'h3800,
                  16'h8000, 4'b0011);
        expect_op("R4 1.5 ulp ties to 2", 16'h0000, 16'h0001, 16'h3E00, 16'h8002, 4'b0011);
        expect_op("R4 max subnormal rounds to min normal", 16'h03FF, 16'h0001, 16'hB800,
                  16'h0400, 4'b0011);
        expect_op("R4 exact subnormal no flags", 16'h0002, 16'h0001, 16'h3C00,
                  16'h0001, 4'b0000);
    endtask

    task automatic test_invalid();
        expect_op("R5 inf*0", 16'h3C00, 16'h7C00, 16'h0000, 16'h7E00, 4'b1000);
        expect_op("R5 0*inf", 16'h3C00, 16'h0000, 16'hFC00, 16'h7E00, 4'b1000);
        expect_op("R5 inf minus inf", 16'h7C00, 16'h7C00, 16'h3C00, 16'h7E00, 4'b1000);
    endtask

    task automatic test_nan();
        expect_op("R6 R7 addend qNaN before mcand sNaN", 16'h7E01, 16'h7D00, 16'h3C00,
                  16'h7E01, 4'b1000);
        expect_op("R6 mcand NaN sign inverted", 16'h3C00, 16'h7E05, 16'h3C00,
                  16'hFE05, 4'b0000);
        expect_op("R7 mplier sNaN quieted", 16'h3C00, 16'h3C00, 16'h7C01, 16'h7E01, 4'b1000);
        expect_op("R7 addend sNaN negative", 16'hFD00, 16'h3C00, 16'h3C00, 16'hFF00, 4'b1000);
    endtask

    task automatic test_zero_sign();
        expect_op("R8 exact cancel +0", 16'h3C00, 16'h3C00, 16'h3C00, 16'h0000, 4'b0000);
        expect_op("R8 -0 plus -0", 16'h8000, 16'h0000, 16'h3C00, 16'h8000, 4'b0000);
        expect_op("R8 +0 plus -0", 16'h0000, 16'h0000, 16'h3C00, 16'h0000, 4'b0000);
        expect_op("R8 -0 minus -0*1", 16'h8000, 16'h8000, 16'h3C00, 16'h0000, 4'b0000);
        expect_op("R8 negative cancel +0", 16'hBC00, 16'hBC00, 16'h3C00, 16'h0000, 4'b0000);
    endtask

    task automatic test_infinity();
        expect_op("R9 inf plus inf", 16'h7C00, 16'hFC00, 16'h3C00, 16'h7C00, 4'b0000);
        expect_op("R9 infinite product", 16'h3C00, 16'h3C00, 16'h7C00, 16'hFC00, 4'b0000);
        expect_op("R9 infinite addend", 16'hFC00, 16'h4000, 16'h4000, 16'hFC00, 4'b0000);
    endtask

    task automatic test_backpressure();
        logic [15:0] held;
        @(negedge clk);
        in_addend = 16'h4200; in_mcand = 16'h3C00; in_mplier = 16'h4000; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        held = out_result;
        check_val("R12 result before stall", {16'd0, held}, 32'h3C00);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_val("R12 out_valid held", 32'(out_valid), 32'd1);
            check_val("R12 result held", {16'd0, out_result}, {16'd0, held});
            check_val("R10 in_ready low in hold", 32'(in_ready), 32'd0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check_val("R12 retire to idle", {30'd0, in_ready, out_valid}, 32'h2);
    endtask

    task automatic test_random();
        logic [15:0] c, a, b, r;
        logic [3:0] f;
        logic [19:0] e;
        for (int i = 0; i < 600; i++) begin
            seed = xs_next(seed); c = seed[15:0]; a = seed[31:16];
            seed = xs_next(seed); b = seed[15:0];
            unique case (seed[17:16])
                2'd0: ;
                2'd1: begin // near cancellation
                    b = {seed[20], 5'd15, 5'd0, seed[25:21]};
                    c = {~(a[15] ^ b[15]) ^ 1'b1, a[14:0] ^ {12'd0, seed[28:26]}};
                end
                2'd2: begin // tiny exponents
                    c[14:10] = {3'd0, seed[19:18]};
                    a[14:10] = {2'd0, seed[22:20]};
                    b[14:10] = 5'd14 + {3'd0, seed[24:23]};
                end
                default: begin // keep finite, wide spread
                    if (c[14:10] == 5'h1F) c[14] = 1'b0;
                    if (a[14:10] == 5'h1F) a[14] = 1'b0;
                    if (b[14:10] == 5'h1F) b[14] = 1'b0;
                end
            endcase
            apply(c, a, b, r, f);
            e = ref_model(c, a, b);
            check_val("R1 R4 random vs reference", {12'd0, f, r}, {12'd0, e});
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_round_even();
        test_overflow();
        test_subnormal();
        test_invalid();
        test_nan();
        test_zero_sign();
        test_infinity();
        test_backpressure();
        test_random();
        finish_run();
    end
endmodule